// File: doc/BRIEF.md
# Seven-to-one serial word framer

This block turns a 7:1 serialized video link back into parallel words. It runs on a sampling clock at seven times the word rate. On every cycle it shifts one bit from each data lane into a per-lane shift register. It samples the link's clock lane into a shift register of its own, in exactly the same way as a data lane. The clock lane repeats a fixed seven-bit shape. The rising edge inside that shape marks where a word starts, so no phase relation to a separately generated slow clock is needed.

Each time the boundary comes around, the block copies the aligned seven-bit slice of every lane into an output register. In the same cycle it pulses a word-rate strobe. The word-rate phase counter is re-anchored to every clock-lane edge it detects. A lock flag reports when the edges have arrived where the counter expects them for several words in a row. Only words captured under lock are marked valid. If the expected edge is missing, the block stops capturing and holds its last word until it finds a new edge.

Top module: `lfr_framer`

## Requirements
- R1: Output bit `word_o[7*k + i]` is the i-th bit received on data lane k within the word, where i = 0 is the first bit received.
- R2: The clock lane carries the bits 1,1,0,0,0,1,1 per word, in reception order. A word is the seven bits that begin two bit-cycles after a 0-to-1 change on the clock lane.
- R3: `word_stb_o` is high for one cycle with every change of `word_o`, and is low on the six cycles between words. `word_o` never changes without it.
- R4: The output register and the strobe update on the clock edge that shifts in the first bit of the following word.
- R5: `locked_o` rises once the edge has been found at the expected position in 4 (LOCK_WORDS) consecutive words after the word that set the boundary. It is high when the fourth such word is presented.
- R6: If the expected clock-lane edge is missing, `locked_o` falls and capture stops. The next edge sets a new boundary, and locking starts over from that word.
- R7: `word_valid_o` is high only together with `word_stb_o`, and only for words captured while locked.
- R8: While no boundary is held, `word_o` keeps the last captured word and `word_stb_o` and `word_valid_o` stay low, whatever the data lanes carry.
- R9: A synchronous active-high reset clears the shift registers, the phase counter, the lock state and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_7x_i | input | 1 | Bit-rate sampling clock, seven times the word rate |
| rst_i | input | 1 | Synchronous active-high reset |
| clk_lane_i | input | 1 | Sampled clock lane of the link |
| data_lanes_i | input | LANES (4) | One serial bit per data lane per cycle |
| word_o | output | 7*LANES (28) | Captured word, lane k in bits 7k+6..7k |
| word_stb_o | output | 1 | One-cycle pulse when word_o updates |
| word_valid_o | output | 1 | Captured word was framed under lock |
| locked_o | output | 1 | Boundary confirmed on consecutive words |

## Verification
Suppose the phase counter is off by even one position. Every captured word then shows rotated lane bits at the first strobe, and the edge check fails, so `locked_o` drops within one word time. Suppose instead the lock counter is wrong. The valid marking then moves earlier or later by whole words after an alignment or a slip, which the bench sees at the capture of the fourth word. Damage to the hold or strobe logic shows as extra strobes or a changed `word_o` during a stretch with no clock-lane edges.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   // bits per lane per word; the clock-lane shape below is tied to this
   localparam int unsigned SYM_BITS = 7;
   // bit index (reception order) at which the clock lane rises inside a word
   localparam int unsigned EDGE_POS = 5;
   localparam int unsigned PHASE_W  = $clog2(SYM_BITS);
   typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/lfr_lane_shift.sv
module lfr_lane_shift #(
   parameter int unsigned DEPTH = 7
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             bit_i,
   output logic [DEPTH-1:0] sr_o
);
   // newest bit enters at the top, so the oldest one ends up in bit 0
   always_ff @(posedge clk_i) begin
      if (rst_i) sr_o <= '0;
      else       sr_o <= {bit_i, sr_o[DEPTH-1:1]};
   end
endmodule

// File: rtl/lfr_frame_track.sv
module lfr_frame_track
   import lfr_pkg::*;
#(
   parameter int unsigned LOCK_WORDS = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic edge_i,
   output logic capture_o,
   output logic locked_o
);
   localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);
   localparam phase_t LAST_PH = phase_t'(SYM_BITS - 1);
   localparam phase_t EDGE_PH = phase_t'(EDGE_POS);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_WORDS);

   phase_t           phase_q, phase_d;
   logic             anchored_q, anchored_d;
   logic [CNT_W-1:0] good_q, good_d;
   logic             due;

   // the phase tells which bit index now sits at the top of the shift registers
   assign due = anchored_q && (phase_q == EDGE_PH);

   always_comb begin
      phase_d    = (phase_q == LAST_PH) ? '0 : phase_q + phase_t'(1);
      anchored_d = anchored_q;
      good_d     = good_q;
      if (edge_i) begin
         phase_d    = LAST_PH;
         anchored_d = 1'b1;
         if (!anchored_q)
            good_d = '0;
         else if (phase_q == EDGE_PH)
            good_d = (good_q == CNT_TOP) ? good_q : good_q + 1'b1;
         else
            good_d = '0;
      end else if (due) begin
         anchored_d = 1'b0;
         good_d     = '0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q    <= '0;
         anchored_q <= 1'b0;
         good_q     <= '0;
      end else begin
         phase_q    <= phase_d;
         anchored_q <= anchored_d;
         good_q     <= good_d;
      end
   end

   assign capture_o = anchored_q && (phase_q == LAST_PH);
   assign locked_o  = (good_q == CNT_TOP);
endmodule

// File: rtl/lfr_word_hold.sv
module lfr_word_hold #(
   parameter int unsigned WIDTH = 28
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             capture_i,
   input  logic             locked_i,
   input  logic [WIDTH-1:0] slices_i,
   output logic [WIDTH-1:0] word_o,
   output logic             stb_o,
   output logic             valid_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         word_o  <= '0;
         stb_o   <= 1'b0;
         valid_o <= 1'b0;
      end else begin
         if (capture_i) word_o <= slices_i;
         stb_o   <= capture_i;
         valid_o <= capture_i & locked_i;
      end
   end
endmodule

// File: rtl/lfr_framer.sv
module lfr_framer
   import lfr_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned LOCK_WORDS = 4
) (
   input  logic                         clk_7x_i,
   input  logic                         rst_i,
   input  logic                         clk_lane_i,
   input  logic [LANES-1:0]             data_lanes_i,
   output logic [LANES*SYM_BITS-1:0]    word_o,
   output logic                         word_stb_o,
   output logic                         word_valid_o,
   output logic                         locked_o
);
   localparam int unsigned WORD_W = LANES * SYM_BITS;
   localparam int unsigned REF    = LANES;   // index of the clock-lane shifter

   if (LANES < 1) begin : g_bad_lanes
      $error("lfr_framer: LANES must be at least 1");
   end
   if (LOCK_WORDS < 1) begin : g_bad_lock
      $error("lfr_framer: LOCK_WORDS must be at least 1");
   end
   if (SYM_BITS != 7 || EDGE_POS != SYM_BITS - 2) begin : g_bad_shape
      $error("lfr_framer: clock-lane shape requires 7 bits with the rise at bit 5");
   end

   logic [SYM_BITS-1:0] sr [LANES+1];
   logic [WORD_W-1:0]   slices;
   logic                edge_seen, capture, locked;

   for (genvar g = 0; g <= LANES; g++) begin : g_lane
      logic in_bit;
      if (g == REF) begin : g_ref
         assign in_bit = clk_lane_i;
      end else begin : g_dat
         assign in_bit = data_lanes_i[g];
         assign slices[g*SYM_BITS +: SYM_BITS] = sr[g];
      end
      lfr_lane_shift #(.DEPTH(SYM_BITS)) u_shift (
         .clk_i (clk_7x_i),
         .rst_i (rst_i),
         .bit_i (in_bit),
         .sr_o  (sr[g])
      );
   end

   // newest clock-lane bit high, the one before it low
   assign edge_seen = sr[REF][SYM_BITS-1] & ~sr[REF][SYM_BITS-2];

   lfr_frame_track #(.LOCK_WORDS(LOCK_WORDS)) u_track (
      .clk_i     (clk_7x_i),
      .rst_i     (rst_i),
      .edge_i    (edge_seen),
      .capture_o (capture),
      .locked_o  (locked)
   );

   lfr_word_hold #(.WIDTH(WORD_W)) u_hold (
      .clk_i     (clk_7x_i),
      .rst_i     (rst_i),
      .capture_i (capture),
      .locked_i  (locked),
      .slices_i  (slices),
      .word_o    (word_o),
      .stb_o     (word_stb_o),
      .valid_o   (word_valid_o)
   );

   assign locked_o = locked;
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
   parameter int unsigned WW = 28
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic [WW-1:0] word_i,
   input logic          stb_i,
   input logic          valid_i,
   input logic          locked_i
);
   logic [2:0] gap_q;
   logic       seen_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (stb_i) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
         end else if (gap_q != 3'd7) begin
            gap_q <= gap_q + 3'd1;
         end
      end
   end

   // R3: two strobes are at least one word time apart
   a_r3_strobe_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_i && seen_q) |-> (gap_q >= 3'd6));

   // R3: the word only changes on a strobe cycle
   a_r3_word_moves_with_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(word_i) |-> stb_i);

   // R7: valid only rides on a strobe
   a_r7_valid_needs_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |-> stb_i);

   // R7: valid only for a word captured while lock was held
   a_r7_valid_needs_lock: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_i |-> $past(locked_i));
endmodule

bind lfr_framer lfr_checker #(.WW(LANES * lfr_pkg::SYM_BITS)) u_lfr_chk (
   .clk_i    (clk_7x_i),
   .rst_i    (rst_i),
   .word_i   (word_o),
   .stb_i    (word_stb_o),
   .valid_i  (word_valid_o),
   .locked_i (locked_o)
);

// File: tb/lfr_framer_tb_top.sv
module lfr_framer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;
   localparam int WB = 7;
   localparam int LOCKN = 4;
   localparam logic [6:0] SHAPE = 7'b1100011; // bit i = clock lane at bit i

   logic              clk = 1'b0;
   logic              rst;
   logic              clk_lane;
   logic [NL-1:0]     lanes;
   logic [NL*WB-1:0]  word;
   logic              stb, valid, locked;

   int checks = 0;
   int errors = 0;
   logic [NL*WB-1:0] prev_w;
   bit               prev_valid;
   int               good;
   bit               finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfr_framer dut_i (
      .clk_7x_i     (clk),
      .rst_i        (rst),
      .clk_lane_i   (clk_lane),
      .data_lanes_i (lanes),
      .word_o       (word),
      .word_stb_o   (stb),
      .word_valid_o (valid),
      .locked_o     (locked)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [NL*WB-1:0] pat(input int n);
      logic [31:0] x;
      x = 32'h9E37_79B9 * (n + 3);
      x = x ^ (x >> 13) ^ 32'h0A5C_3E71;
      return x[NL*WB-1:0];
   endfunction

   // called right after the posedge that shifts the first bit after a word
   task automatic check_capture(input string locktag);
      chk(stb == 1'b1, "R3 R4 strobe at capture", 32'(stb), 32'd1);
      chk(word == prev_w, "R1 R2 captured word", 32'(word), 32'(prev_w));
      chk(valid == prev_valid, "R7 valid marking", 32'(valid), 32'(prev_valid));
      chk(locked == prev_valid, locktag, 32'(locked), 32'(prev_valid));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; clk_lane = 1'b0; lanes = '0;
      repeat (3) @(negedge clk);
      chk(word == '0 && stb == 1'b0 && valid == 1'b0 && locked == 1'b0,
          "R9 reset state", {word[27:0], stb, valid, locked}, 32'd0);
      rst = 1'b0;
   endtask

   // tail of a word (bits 2..6) with zero data, so the first boundary is found
   task automatic send_lead();
      for (int i = 2; i < WB; i++) begin
         @(negedge clk);
         clk_lane = SHAPE[i]; lanes = '0;
         @(posedge clk);
      end
      prev_w = '0; prev_valid = 1'b0; good = 0;
   endtask

   task automatic send_word(input logic [NL*WB-1:0] w, input bit realign, input bit capchk);
      bit quiet = 1'b1;
      for (int i = 0; i < WB; i++) begin
         @(negedge clk);
         clk_lane = SHAPE[i];
         for (int l = 0; l < NL; l++) lanes[l] = w[l*WB + i];
         @(posedge clk); #1;
         if (i == 0 && capchk) check_capture("R5 lock state");
         else if (i > 0 && stb) quiet = 1'b0;
      end
      chk(quiet, "R3 no strobe between words", 32'(!quiet), 32'd0);
      good = realign ? 0 : good + 1;
      prev_w = w;
      prev_valid = (good >= LOCKN);
   endtask

   task automatic scen_lock_up();
      send_lead();
      for (int n = 0; n < 7; n++) send_word(pat(n), 1'b0, 1'b1);
      chk(locked == 1'b1, "R5 locked after run", 32'(locked), 32'd1);
   endtask

   // two extra clock-high bits push the next edge late
   task automatic scen_slip();
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         clk_lane = 1'b1; lanes = '1;
         @(posedge clk); #1;
         if (i == 0) check_capture("R5 lock before slip");
      end
      send_word(pat(20), 1'b1, 1'b0);
      chk(locked == 1'b0, "R6 lock lost after missing edge", 32'(locked), 32'd0);
      for (int n = 21; n < 27; n++) send_word(pat(n), 1'b0, 1'b1);
   endtask

   // clock lane stuck high: no edges, data keeps toggling
   task automatic scen_hold();
      bit ok = 1'b1;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         clk_lane = 1'b1; lanes = NL'(i * 5 + 3);
         @(posedge clk); #1;
         if (i == 0) check_capture("R5 lock before stall");
         else if (stb || valid || word != prev_w) ok = 1'b0;
      end
      chk(ok, "R8 word held without boundary", 32'(word), 32'(prev_w));
      chk(locked == 1'b0, "R6 lock dropped in stall", 32'(locked), 32'd0);
      send_word(pat(40), 1'b1, 1'b0);
      send_word(28'h0000000, 1'b0, 1'b1);
      send_word(28'hFFFFFFF, 1'b0, 1'b1);
      for (int n = 41; n < 45; n++) send_word(pat(n), 1'b0, 1'b1);
   endtask

   task automatic scen_reset_mid();
      do_reset();
      send_lead();
      send_word(28'h0000001, 1'b0, 1'b1);
      send_word(28'h8000000, 1'b0, 1'b1);
      send_word(28'h1020408, 1'b0, 1'b1);
      send_word(28'h7F00000, 1'b0, 1'b1);
      send_word(pat(60), 1'b0, 1'b1);
      send_word(pat(61), 1'b0, 1'b1);
   endtask

   initial begin
      rst = 1'b1; clk_lane = 1'b0; lanes = '0;
      prev_w = '0; prev_valid = 1'b0; good = 0;
      do_reset();
      scen_lock_up();
      scen_slip();
      scen_hold();
      scen_reset_mid();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule